// File: doc/BRIEF.md
# Eight-Source Vectored Interrupt Controller

This block collects eight interrupt request lines from the peripherals of a video subsystem and merges them into one group interrupt to the processor. The sources are a serial controller, vertical sync, the mouse, cursor start, three mouse buttons and a spare. Software configures the block through a small register port. The port has a mode register, a single data port whose target register is picked by a select field in the mode register, a read-only status word, and an eight-entry vector table.

Each source has four state bits: request, mask, in-service and auto-clear. A source is pending when its request bit is 1 and its mask bit is 0. When the processor acknowledges, the lowest-numbered pending source wins. The block returns that source's vector-table entry plus a fixed base, drops the source's request bit and updates its in-service bit according to its auto-clear bit. A peripheral clear line removes both the request and the in-service bit of a source.

Top module: `grp_irq_ctrl`

## Requirements
- R1: After reset the mode register reads 0x80, the status word reads 0x48, the request, mask, in-service and auto-clear registers read 0, all vector entries read 0 and irq_o is 0.
- R2: irq_o is 1 exactly when irq_en_i is 1, mode bit 7 (master mask) is 1, mode bit 2 (polled) is 0 and at least one source is pending (request 1, mask 0). The output follows state changes and irq_en_i without extra delay.
- R3: A data-port access (word address 0) targets the register selected by mode bits 6:5: 0 in-service, 1 mask, 2 request, 3 auto-clear. Writes load the selected register and reads return it.
- R4: The status word (address 2, writes have no effect) holds the lowest pending source index in bits 2:0 (0 when none is pending), master mask in bit 3, polled mode in bit 4, mode bit 0 in bit 5, a constant 1 in bit 6, and in bit 7 the group flag (master mask set, polled clear, one source pending).
- R5: On ack_i with a source pending, the lowest-indexed pending source wins. Its request bit is cleared. Its in-service bit is cleared if its auto-clear bit is 1 and set otherwise. vec_o shows its vector entry plus VEC_BASE (0x100) from the next cycle.
- R6: On ack_i with no source pending, vec_o becomes 0 and no register changes.
- R7: src_set_i bits set request bits. src_clr_i bits clear both the request and in-service bits of their sources and win over a set in the same cycle.
- R8: Vector entry i is written and read at word address 8+i.
- R9: The mode register is written and read at word address 1. Reads return data on rdata_o in the cycle after rd_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 5 | Register word address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, registered |
| src_set_i | input | 8 | Per-source request set pulses |
| src_clr_i | input | 8 | Per-source request and in-service clear pulses |
| irq_en_i | input | 1 | Interrupt enable from the outer control register |
| ack_i | input | 1 | Interrupt acknowledge pulse |
| vec_o | output | 9 | Vector returned by the last acknowledge |
| irq_o | output | 1 | Group interrupt to the processor |

## Verification
The hardest thing to reach from the ports is a long chain of acknowledges against mixed auto-clear settings. Each acknowledge changes which source wins the next one, so errors in the in-service toggling and in the winner removal add up over the chain. The bench loads all eight requests and a mixed auto-clear mask through the data port. It then acknowledges until nothing is pending and checks every vector, the final in-service pattern and the empty acknowledge that follows. A sweep over all 256 mask values, crossed with several request patterns and enable/mode settings, checks the group output and the status index arithmetically.

// File: rtl/grp_irq_pkg.sv
package grp_irq_pkg;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned DATA_W = 8;

  localparam logic [ADDR_W-1:0] A_DATA = 5'd0;
  localparam logic [ADDR_W-1:0] A_MODE = 5'd1;
  localparam logic [ADDR_W-1:0] A_STAT = 5'd2;
  localparam logic [ADDR_W-1:0] A_VTAB = 5'd8;

  localparam int unsigned MB_PRIO  = 0;
  localparam int unsigned MB_VSEL  = 1;
  localparam int unsigned MB_POLL  = 2;
  localparam int unsigned MB_GPOL  = 3;
  localparam int unsigned MB_RPOL  = 4;
  localparam int unsigned MB_SELLO = 5;
  localparam int unsigned MB_MMASK = 7;

  localparam logic [DATA_W-1:0] MODE_RST = 8'h80;

  typedef enum logic [1:0] {
    SEL_ISR = 2'd0,
    SEL_IMR = 2'd1,
    SEL_IRR = 2'd2,
    SEL_ACR = 2'd3
  } sel_e;
endpackage

// File: rtl/grp_irq_prio.sv
module grp_irq_prio #(
  parameter int unsigned N     = 8,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [N-1:0]     oh_o
);
  // scan downward so the lowest set index is the last to assign
  always_comb begin
    idx_o = '0;
    oh_o  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        idx_o = IDX_W'(i);
        oh_o  = N'(1) << i;
      end
    end
    any_o = |req_i;
  end
endmodule

// File: rtl/grp_irq_vtab.sv
module grp_irq_vtab #(
  parameter int unsigned N     = 8,
  parameter int unsigned W     = 8,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  logic [W-1:0]     wdata_i,
  input  logic [IDX_W-1:0] ridx_a_i,
  input  logic [IDX_W-1:0] ridx_b_i,
  output logic [W-1:0]     rdata_a_o,
  output logic [W-1:0]     rdata_b_o
);
  logic [W-1:0] ent_q [N];

  for (genvar g = 0; g < N; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   ent_q[g] <= '0;
      else if (we_i && widx_i == IDX_W'(g))          ent_q[g] <= wdata_i;
    end
  end

  assign rdata_a_o = ent_q[ridx_a_i];
  assign rdata_b_o = ent_q[ridx_b_i];
endmodule

// File: rtl/grp_irq_ctrl.sv
module grp_irq_ctrl
  import grp_irq_pkg::*;
#(
  parameter int unsigned N        = 8,
  parameter int unsigned VEC_W    = 8,
  parameter int unsigned OUT_W    = VEC_W + 1,
  parameter logic [OUT_W-1:0] VEC_BASE = 9'h100
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                wr_i,
  input  logic                rd_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  input  logic [N-1:0]        src_set_i,
  input  logic [N-1:0]        src_clr_i,
  input  logic                irq_en_i,
  input  logic                ack_i,
  output logic [OUT_W-1:0]    vec_o,
  output logic                irq_o
);
  localparam int unsigned IDX_W = $clog2(N);

  logic [N-1:0]      irr_q, imr_q, isr_q, acr_q;
  logic [N-1:0]      irr_d, imr_d, isr_d, acr_d;
  logic [DATA_W-1:0] mode_q;
  logic [N-1:0]      pend, win_oh;
  logic              pend_any, grp_flag;
  logic [IDX_W-1:0]  win_idx;
  logic [VEC_W-1:0]  vt_rd, vt_win;
  logic              vt_hit, dp_wr, ack_hit;
  logic [IDX_W-1:0]  vt_idx;
  logic [DATA_W-1:0] stat_w, dp_rd, rd_mux;
  sel_e              sel;

  assign pend     = irr_q & ~imr_q;
  assign sel      = sel_e'(mode_q[MB_SELLO+1:MB_SELLO]);
  assign grp_flag = mode_q[MB_MMASK] & ~mode_q[MB_POLL] & pend_any;
  assign irq_o    = grp_flag & irq_en_i;
  assign vt_hit   = (addr_i >= A_VTAB) && (addr_i < A_VTAB + ADDR_W'(N));
  assign vt_idx   = IDX_W'(addr_i - A_VTAB);
  assign dp_wr    = wr_i && addr_i == A_DATA;
  assign ack_hit  = ack_i && pend_any;

  grp_irq_prio #(.N(N)) u_prio (
    .req_i (pend),
    .any_o (pend_any),
    .idx_o (win_idx),
    .oh_o  (win_oh)
  );

  grp_irq_vtab #(.N(N), .W(VEC_W)) u_vtab (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (wr_i && vt_hit),
    .widx_i    (vt_idx),
    .wdata_i   (wdata_i[VEC_W-1:0]),
    .ridx_a_i  (vt_idx),
    .ridx_b_i  (win_idx),
    .rdata_a_o (vt_rd),
    .rdata_b_o (vt_win)
  );

  // order: port write, peripheral set, acknowledge, peripheral clear
  always_comb begin
    irr_d = irr_q;
    imr_d = imr_q;
    isr_d = isr_q;
    acr_d = acr_q;
    if (dp_wr) begin
      unique case (sel)
        SEL_ISR: isr_d = wdata_i[N-1:0];
        SEL_IMR: imr_d = wdata_i[N-1:0];
        SEL_IRR: irr_d = wdata_i[N-1:0];
        SEL_ACR: acr_d = wdata_i[N-1:0];
      endcase
    end
    irr_d = irr_d | src_set_i;
    if (ack_hit) begin
      irr_d = irr_d & ~win_oh;
      if (|(acr_q & win_oh)) isr_d = isr_d & ~win_oh;
      else                   isr_d = isr_d | win_oh;
    end
    irr_d = irr_d & ~src_clr_i;
    isr_d = isr_d & ~src_clr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irr_q  <= '0;
      imr_q  <= '0;
      isr_q  <= '0;
      acr_q  <= '0;
      mode_q <= MODE_RST;
    end else begin
      irr_q <= irr_d;
      imr_q <= imr_d;
      isr_q <= isr_d;
      acr_q <= acr_d;
      if (wr_i && addr_i == A_MODE) mode_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    vec_o <= '0;
    else if (ack_i) vec_o <= ack_hit ? (OUT_W'(vt_win) + VEC_BASE) : '0;
  end

  assign stat_w = {grp_flag, 1'b1, mode_q[MB_PRIO], mode_q[MB_POLL],
                   mode_q[MB_MMASK], 3'(win_idx)};

  always_comb begin
    unique case (sel)
      SEL_ISR: dp_rd = DATA_W'(isr_q);
      SEL_IMR: dp_rd = DATA_W'(imr_q);
      SEL_IRR: dp_rd = DATA_W'(irr_q);
      SEL_ACR: dp_rd = DATA_W'(acr_q);
    endcase
  end

  always_comb begin
    if (vt_hit)                rd_mux = DATA_W'(vt_rd);
    else if (addr_i == A_DATA) rd_mux = dp_rd;
    else if (addr_i == A_MODE) rd_mux = mode_q;
    else if (addr_i == A_STAT) rd_mux = stat_w;
    else                       rd_mux = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_mux;
  end
endmodule

// File: rtl/grp_irq_ctrl_chk.sv
module grp_irq_ctrl_chk
  import grp_irq_pkg::*;
#(
  parameter int unsigned N     = 8,
  parameter int unsigned OUT_W = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_i,
  input logic              rd_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [N-1:0]      src_set_i,
  input logic [N-1:0]      src_clr_i,
  input logic              irq_en_i,
  input logic              ack_i,
  input logic [OUT_W-1:0]  vec_o,
  input logic              irq_o,
  input logic [N-1:0]      irr_s,
  input logic [N-1:0]      imr_s,
  input logic [DATA_W-1:0] mode_s
);
  logic [N-1:0] pend_s, low_s;
  assign pend_s = irr_s & ~imr_s;
  assign low_s  = pend_s & (~pend_s + 1'b1);

  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (irq_en_i && mode_s[MB_MMASK] && !mode_s[MB_POLL] && (|pend_s))); // R2

  AST_EMPTY_ACK_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !(|pend_s)) |=> (vec_o == '0)); // R6

  AST_CLR_DROPS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|src_clr_i) |=> ((irr_s & $past(src_clr_i)) == '0)); // R7

  AST_STAT_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == A_STAT) |=> rdata_o[6]); // R4

  AST_ACK_DROPS_WIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && (|pend_s) && !(|src_set_i) && !wr_i) |=> ((irr_s & $past(low_s)) == '0)); // R5
endmodule

bind grp_irq_ctrl grp_irq_ctrl_chk #(.N(N), .OUT_W(OUT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .wr_i      (wr_i),
  .rd_i      (rd_i),
  .rdata_o   (rdata_o),
  .src_set_i (src_set_i),
  .src_clr_i (src_clr_i),
  .irq_en_i  (irq_en_i),
  .ack_i     (ack_i),
  .vec_o     (vec_o),
  .irq_o     (irq_o),
  .irr_s     (irr_q),
  .imr_s     (imr_q),
  .mode_s    (mode_q)
);

// File: tb/grp_irq_ctrl_test.sv
`timescale 1ns/1ps
module grp_irq_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] addr = '0;
  logic       wr = 1'b0, rd = 1'b0, ack = 1'b0, en = 1'b0;
  logic [7:0] wdata = '0, set = '0, clr = '0;
  logic [7:0] rdata;
  logic [8:0] vec;
  logic       irq;
  int total = 0, bad = 0;
  logic [7:0] vt [8];

  always #4 clk = ~clk;

  grp_irq_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .src_set_i(set), .src_clr_i(clr),
    .irq_en_i(en), .ack_i(ack), .vec_o(vec), .irq_o(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rreg(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  // data-port access with preselect sel; mode other bits kept as m
  task automatic wsel(input logic [7:0] m, input int sel, input logic [7:0] d);
    wreg(5'd1, (m & 8'h9F) | 8'(sel << 5));
    wreg(5'd0, d);
  endtask

  task automatic rsel(input logic [7:0] m, input int sel, output logic [7:0] d);
    wreg(5'd1, (m & 8'h9F) | 8'(sel << 5));
    rreg(5'd0, d);
  endtask

  task automatic do_ack;
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  function automatic int low_idx(input logic [7:0] p);
    for (int i = 0; i < 8; i++) if (p[i]) return i;
    return 0;
  endfunction

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rreg(5'd1, d); chk("R1 mode", d, 8'h80);
    rreg(5'd2, d); chk("R1 status", d, 8'h48);
    chk("R1 irq", irq, 0);
    for (int s = 0; s < 4; s++) begin rsel(8'h80, s, d); chk("R1 dport", d, 0); end
    for (int i = 0; i < 8; i++) begin rreg(5'(8 + i), d); chk("R1 vtab", d, 0); end

    // R8 vector table
    for (int i = 0; i < 8; i++) begin vt[i] = 8'(i * 37 + 5); wreg(5'(8 + i), vt[i]); end
    for (int i = 0; i < 8; i++) begin rreg(5'(8 + i), d); chk("R8 vtab", d, vt[i]); end

    // R9 mode, R3 preselect mapping
    wreg(5'd1, 8'h3B); rreg(5'd1, d); chk("R9 mode", d, 8'h3B);
    for (int s = 0; s < 4; s++) wsel(8'h00, s, 8'(8'h11 * (s + 3)));
    for (int s = 0; s < 4; s++) begin rsel(8'h00, s, d); chk("R3 dport", d, 8'h11 * (s + 3)); end
    wreg(5'd2, 8'hFF); wreg(5'd1, 8'h00);
    rreg(5'd2, d); chk("R4 status wr ignored", d, 8'h40 | low_idx(8'h55 & ~8'h44));

    // R2/R4 sweep over all masks
    for (int m = 0; m < 256; m++) begin
      for (int k = 0; k < 3; k++) begin
        logic [7:0] p, pend, md;
        logic mm, pl, e, grp;
        p  = (k == 0) ? 8'h80 : (k == 1) ? 8'hFF : (8'(m) ^ 8'h5A);
        mm = (m % 3) != 0;
        pl = (m % 5) == 0;
        e  = ((m >> 1) & 1) == (k & 1);
        md = {mm, 2'b00, 1'b0, 1'b0, pl, 1'b0, 1'(m & 1)};
        wsel(md, 1, 8'(m));
        wsel(md, 2, p);
        wreg(5'd1, md);
        @(negedge clk); en = e;
        pend = p & ~8'(m);
        grp  = mm && !pl && (pend != 0);
        @(negedge clk);
        chk("R2 irq", irq, grp && e);
        rreg(5'd2, d);
        chk("R4 status", d, {grp, 1'b1, 1'(m & 1), pl, mm, 3'(low_idx(pend))});
      end
    end

    // R5/R6 acknowledge chain
    en = 1'b1;
    wsel(8'h80, 1, 8'h00);
    wsel(8'h80, 3, 8'h55);
    wsel(8'h80, 0, 8'h00);
    wsel(8'h80, 2, 8'hFF);
    wreg(5'd1, 8'h80);
    for (int i = 0; i < 8; i++) begin
      do_ack;
      chk("R5 vec", vec, 9'h100 + vt[i]);
    end
    chk("R2 irq none", irq, 0);
    rsel(8'h80, 0, d); chk("R5 isr", d, 8'hAA);
    rsel(8'h80, 2, d); chk("R5 irr", d, 8'h00);
    do_ack; chk("R6 vec empty", vec, 0);
    rsel(8'h80, 0, d); chk("R6 isr kept", d, 8'hAA);

    // R5 masked sources skipped
    wsel(8'h80, 1, 8'h07);
    wsel(8'h80, 2, 8'h0F);
    wreg(5'd1, 8'h80);
    do_ack; chk("R5 masked skip", vec, 9'h100 + vt[3]);
    rsel(8'h80, 2, d); chk("R5 masked irr", d, 8'h07);

    // R7 set / clear
    wsel(8'h80, 1, 8'h00);
    wsel(8'h80, 2, 8'h00);
    wsel(8'h80, 0, 8'hF0);
    wreg(5'd1, 8'h80);
    @(negedge clk); set = 8'h24;
    @(negedge clk); set = 8'h00;
    chk("R7 set irq", irq, 1);
    rsel(8'h80, 2, d); chk("R7 set irr", d, 8'h24);
    wreg(5'd1, 8'h80);
    @(negedge clk); clr = 8'h30; set = 8'h10;
    @(negedge clk); clr = 8'h00; set = 8'h00;
    rsel(8'h80, 2, d); chk("R7 clr irr", d, 8'h04);
    rsel(8'h80, 0, d); chk("R7 clr isr", d, 8'hC0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule